// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block watches eight already-synchronised interrupt lines and turns activity on them into per-line interrupt requests. Each line has a two-bit sense code from the surrounding configuration logic that selects low-level, any-change, falling-edge or rising-edge detection. In the three edge modes a detected event sets a sticky flag, and the line requests service while that flag, its enable bit and the global interrupt-enable input are all 1. In low-level mode no flag is kept: the request follows the inverted line level directly, gated by the same enables.

Software reaches two 8-bit registers over a small synchronous bus: an enable register and a flag register. Flags are cleared by writing ones to them, or by a per-line acknowledge pulse from the vector logic when the handler is entered. A line is sampled whatever drives it, so a pin that software drives as an output can be toggled to raise an interrupt under program control.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the enable register and the flag register both read 0x00 and every request output is 0.
- R2: A write with `addr_i`=0 loads `wdata_i` into the enable register, which reads back unchanged on address 0; a write to address 1 does not alter it.
- R3: With sense code 2'b11 a 0-to-1 change of a line sets its flag (read on address 1, bit i = line i) on the clock edge that samples the new level; a 1-to-0 change does not.
- R4: With sense code 2'b10 a 1-to-0 change sets the flag; a 0-to-1 change does not.
- R5: With sense code 2'b01 any change of level sets the flag.
- R6: In edge modes `req_o[i]` is 1 exactly when flag i, enable bit i and `gie_i` are all 1; a flag is set whether or not its enable bit is 1.
- R7: Writing to address 1 clears every flag whose `wdata_i` bit is 1 and leaves flags with a 0 bit unchanged.
- R8: A 1 on `ack_i[i]` for one cycle clears flag i.
- R9: When a line's set event falls in the same cycle as a write-one clear or an acknowledge of that line, the flag ends up set.
- R10: With sense code 2'b00 the line's flag reads 0 (a previously set flag is dropped), and `req_o[i]` is 1 exactly when the line is low, enable bit i is 1 and `gie_i` is 1, with no clock delay.
- R11: A line that is already high or low when reset is released does not set its flag in the first cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 8 | Synchronised interrupt lines, bit i = line i |
| sense_i | input | 16 | Sense code per line, bits [2i+1:2i] for line i |
| gie_i | input | 1 | Global interrupt enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 = enable, 1 = flag |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the register selected by `addr_i` |
| ack_i | input | 8 | Per-line vector acknowledge pulse |
| req_o | output | 8 | Per-line interrupt request |

## Verification
The hardest state to reach is a collision: a set event on a line must land in the very clock cycle in which a clear of the same flag, by bus write or by acknowledge, is also presented. The bench first sets one flag, then in a single cycle raises two further lines while writing a clear for one of them and pulsing the acknowledge for the other, and checks that all three flags read back as 1. A second awkward point is switching a line with a pending flag from edge sense to level sense, which must drop the flag at once.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic ADDR_MASK = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;
endpackage

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_LINES-1:0]     line_i,
  input  logic [2*N_LINES-1:0]   sense_i,
  output logic [N_LINES-1:0]     hit_o,
  output logic [N_LINES-1:0]     level_o
);
  logic [N_LINES-1:0] prev_q;
  logic               armed_q;

  // first cycle after reset only loads prev_q: no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= line_i;
      armed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    sense_e mode;
    logic   rise, fall;
    assign mode = sense_e'(sense_i[2*i +: 2]);
    assign rise = armed_q &  line_i[i] & ~prev_q[i];
    assign fall = armed_q & ~line_i[i] &  prev_q[i];

    always_comb begin
      level_o[i] = 1'b0;
      unique case (mode)
        SENSE_LOW:  begin hit_o[i] = 1'b0; level_o[i] = 1'b1; end
        SENSE_ANY:  hit_o[i] = rise | fall;
        SENSE_FALL: hit_o[i] = fall;
        SENSE_RISE: hit_o[i] = rise;
        default:    hit_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] hit_i,
  input  logic [N_LINES-1:0] level_i,
  input  logic [N_LINES-1:0] clr_i,
  input  logic [N_LINES-1:0] ack_i,
  output logic [N_LINES-1:0] flag_o
);
  logic [N_LINES-1:0] flag_q, flag_d;

  // set beats both clear sources; level mode pins the flag low
  always_comb begin
    flag_d = (hit_i | (flag_q & ~clr_i & ~ack_i)) & ~level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               addr_i,
  input  logic [N_LINES-1:0] wdata_i,
  input  logic [N_LINES-1:0] flag_i,
  input  logic [N_LINES-1:0] level_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] clr_o,
  output logic [N_LINES-1:0] rdata_o
);
  logic [N_LINES-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       mask_q <= '0;
    else if (wr_i && addr_i == ADDR_MASK) mask_q <= wdata_i;
  end

  assign clr_o  = (wr_i && addr_i == ADDR_FLAG) ? wdata_i : '0;
  assign mask_o = mask_q;

  // level lines read 0 even in the cycle the mode changes
  always_comb begin
    if (addr_i == ADDR_FLAG) rdata_o = flag_i & ~level_i;
    else                     rdata_o = mask_q;
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int unsigned N_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_LINES-1:0]   line_i,
  input  logic [2*N_LINES-1:0] sense_i,
  input  logic                 gie_i,
  input  logic                 wr_i,
  input  logic                 addr_i,
  input  logic [N_LINES-1:0]   wdata_i,
  output logic [N_LINES-1:0]   rdata_o,
  input  logic [N_LINES-1:0]   ack_i,
  output logic [N_LINES-1:0]   req_o
);
  logic [N_LINES-1:0] edge_hit, level_mode, flag_q, mask_q, wr_clr;

  ext_irq_detect #(.N_LINES(N_LINES)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .sense_i (sense_i),
    .hit_o   (edge_hit),
    .level_o (level_mode)
  );

  ext_irq_flags #(.N_LINES(N_LINES)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (edge_hit),
    .level_i (level_mode),
    .clr_i   (wr_clr),
    .ack_i   (ack_i),
    .flag_o  (flag_q)
  );

  ext_irq_regs #(.N_LINES(N_LINES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flag_i  (flag_q),
    .level_i (level_mode),
    .mask_o  (mask_q),
    .clr_o   (wr_clr),
    .rdata_o (rdata_o)
  );

  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      req_o[i] = gie_i & mask_q[i] & (level_mode[i] ? ~line_i[i] : flag_q[i]);
    end
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               gie_i,
  input logic               wr_i,
  input logic               addr_i,
  input logic [N_LINES-1:0] wdata_i,
  input logic [N_LINES-1:0] ack_i,
  input logic [N_LINES-1:0] req_o,
  input logic [N_LINES-1:0] hit,
  input logic [N_LINES-1:0] level,
  input logic [N_LINES-1:0] flag_q,
  input logic [N_LINES-1:0] mask_q
);
  p_gie_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> req_o == '0);

  p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_MASK) |=> $stable(mask_q));

  for (genvar i = 0; i < N_LINES; i++) begin : g_chk
    p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == ADDR_FLAG && wdata_i[i] && !hit[i]) |=> !flag_q[i]);

    p_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[i] && !hit[i]) |=> !flag_q[i]);

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[i] |=> flag_q[i]);

    p_level_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level[i] |=> !flag_q[i]);

    p_req_needs_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o[i] |-> mask_q[i]);
  end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .gie_i   (gie_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .ack_i   (ack_i),
  .req_o   (req_o),
  .hit     (edge_hit),
  .level   (level_mode),
  .flag_q  (flag_q),
  .mask_q  (mask_q)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  line = 8'hFF;
  logic [15:0] sense = 16'hFFFF;
  logic        gie = 1'b0;
  logic        wr = 1'b0;
  logic        addr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [7:0]  ack = 8'h00;
  logic [7:0]  req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .sense_i(sense), .gie_i(gie),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ack_i(ack), .req_o(req)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic set_line(input logic [7:0] v);
    @(negedge clk);
    line = v;
    @(negedge clk);
  endtask

  task automatic set_all(input logic [1:0] m);
    for (int i = 0; i < 8; i++) sense[2*i +: 2] = m;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R1 mask", v, 8'h00);
    rd(1'b1, v); chk("R11 flag no false edge", v, 8'h00);
    chk("R1 req", req, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    bus_wr(1'b0, 8'hA5);
    rd(1'b0, v); chk("R2 mask write", v, 8'hA5);
    bus_wr(1'b1, 8'h3C);
    rd(1'b0, v); chk("R2 flag write keeps mask", v, 8'hA5);
    bus_wr(1'b0, 8'hFF);
  endtask

  task automatic t_rise();
    logic [7:0] v;
    set_all(2'b11);
    set_line(8'h00);
    rd(1'b1, v); chk("R3 fall ignored", v, 8'h00);
    set_line(8'h0F);
    rd(1'b1, v); chk("R3 rise sets", v, 8'h0F);
    gie = 1'b1; #1;
    chk("R6 req follows flag", req, 8'h0F);
    bus_wr(1'b0, 8'h03);
    chk("R6 req masked", req, 8'h03);
    gie = 1'b0; #1;
    chk("R6 gie off", req, 8'h00);
    bus_wr(1'b0, 8'hFF);
    bus_wr(1'b1, 8'hFF);
  endtask

  task automatic t_fall();
    logic [7:0] v;
    set_all(2'b10);
    set_line(8'h05);
    rd(1'b1, v); chk("R4 fall sets", v, 8'h0A);
    set_line(8'h0F);
    rd(1'b1, v); chk("R4 rise ignored", v, 8'h0A);
    bus_wr(1'b1, 8'h02);
    rd(1'b1, v); chk("R7 w1c one bit", v, 8'h08);
    bus_wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R7 zero write keeps", v, 8'h08);
    bus_wr(1'b1, 8'hFF);
  endtask

  task automatic t_any();
    logic [7:0] v;
    set_all(2'b01);
    set_line(8'h05);
    set_line(8'h50);
    rd(1'b1, v); chk("R5 any change", v, 8'h5F);
    @(negedge clk); ack = 8'h01;
    @(negedge clk); ack = 8'h00;
    rd(1'b1, v); chk("R8 ack clears", v, 8'h5E);
    bus_wr(1'b1, 8'hFF);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    set_all(2'b11);
    set_line(8'h00);
    bus_wr(1'b1, 8'hFF);
    set_line(8'h02);
    @(negedge clk);
    line = 8'h07; wr = 1'b1; addr = 1'b1; wdata = 8'h01; ack = 8'h04;
    @(negedge clk);
    wr = 1'b0; wdata = 8'h00; ack = 8'h00;
    rd(1'b1, v); chk("R9 set beats clear", v, 8'h07);
    bus_wr(1'b1, 8'hFF);
  endtask

  task automatic t_level();
    logic [7:0] v;
    set_line(8'h08);
    rd(1'b1, v); chk("R3 line3 flag", v, 8'h08);
    @(negedge clk); sense[7:6] = 2'b00; gie = 1'b1;
    #1 rd(1'b1, v); chk("R10 flag dropped", v, 8'h00);
    chk("R10 high no req", req, 8'h00);
    line = 8'h00; #1;
    chk("R10 low requests", req, 8'h08);
    @(negedge clk); @(negedge clk);
    rd(1'b1, v); chk("R10 flag stays 0", v, 8'h00);
    gie = 1'b0; #1;
    chk("R10 gie gates level", req, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_rise();
    t_fall();
    t_any();
    t_collide();
    t_level();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule